// File: doc/BRIEF.md
# Optimal Filter Energy/Time Engine

The engine reduces each readout channel's fixed window of digitised samples to three figures: an energy estimate, an energy-times-phase term from which time can be derived later, and a chi-square quality figure. The energy and the time term are weighted sums over the same sample window, each with its own weight set. The quality figure sums the squared residuals between the samples and a reference pulse shape scaled by the measured energy. Every channel uses the same three coefficient tables. Offline software derives the weights and the pulse shape, then loads them through a small write-only address/data port.

Samples arrive one per accepted cycle on a valid-qualified stream. The engine counts them itself, and every seventh accepted sample closes a channel. Samples of one channel may have idle cycles between them, and a new channel may follow the last one with no gap. Each closed channel yields exactly one result record, always the same number of cycles after its closing sample. All multiplies are 16 by 16 bits and all sums are 32-bit integers.

Top module: `ofe_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid` is 0 and `res_energy`, `res_etime` and `res_chi2` are 0.
- R2: `res_energy` equals the sum over i = 0..6 of S_i × A_i, arithmetically shifted right by 14. S_i is the i-th accepted sample of the channel, a 10-bit unsigned value. A_i is a signed 16-bit Q1.14 weight.
- R3: `res_etime` equals the sum over i of S_i × B_i, arithmetically shifted right by 14, with B_i a second signed Q1.14 weight set.
- R4: `res_chi2` equals the sum over i of r_i². Here r_i = S_i − ((E16 × G_i) >>> 14), E16 is the energy clamped to signed 16 bits, G_i is a signed Q1.14 shape value, and r_i is clamped to signed 16 bits before it is squared.
- R5: The coefficient tables are common to all channels. Equal sample sets give equal records no matter which channel position they occupy.
- R6: `res_valid` pulses for one cycle on the 16th rising edge after the edge that accepted a channel's seventh sample, exactly once per channel.
- R7: The chi-square sum is unsigned and saturates at 0xFFFFFFFF instead of wrapping.
- R8: A write with `cfg_we` = 1 updates bank `cfg_sel` (0 = A, 1 = B, 2 = G) at entry `cfg_addr`. Writes with `cfg_sel` = 3, or with `cfg_addr` of 7 or more, change no coefficient.
- R9: Idle cycles (`smp_valid` = 0) between the samples of one channel do not change its record, and R6 still counts from the seventh sample.
- R10: Channels may follow one another back to back with no idle cycles, and every channel still gets a correct record.
- R11: Between result pulses the three result outputs hold the last record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 2 | Bank select: 0 energy weights, 1 time weights, 2 pulse shape |
| cfg_addr | input | 3 | Entry index within the bank |
| cfg_wdata | input | 16 | Signed Q1.14 coefficient |
| smp_valid | input | 1 | Sample accepted this cycle |
| smp_data | input | 10 | Unsigned sample value |
| res_valid | output | 1 | One-cycle result pulse |
| res_energy | output | 32 | Signed energy |
| res_etime | output | 32 | Signed energy-times-phase term |
| res_chi2 | output | 32 | Unsigned saturating chi-square |

## Verification
Several properties are checked on every cycle. The result pulse must line up with a sample count kept independently from the input stream, 16 edges after each seventh sample. Two pulses may never come in adjacent cycles. The outputs must hold while no pulse is present, and they must be clear right after reset. The arithmetic can only be shown by the bench scenarios, which compare each record against values computed independently in the bench. These scenarios cover zero, full-scale, ramp and pseudo-random sample sets, gapped and back-to-back streams, repeated sample sets, ignored coefficient writes and a forced chi-square saturation.

// File: rtl/ofe_pkg.sv
package ofe_pkg;
  localparam int NBANK = 3;
  typedef enum logic [1:0] {
    BANK_ENERGY = 2'd0,
    BANK_TIME   = 2'd1,
    BANK_SHAPE  = 2'd2,
    BANK_NONE   = 2'd3
  } ofe_bank_e;
endpackage

// File: rtl/ofe_coef_bank.sv
module ofe_coef_bank #(
  parameter int NSAMP = 7,
  parameter int CW    = 16,
  parameter int IDXW  = 3
) (
  input  logic                                          clk,
  input  logic                                          we,
  input  logic [1:0]                                    sel,
  input  logic [IDXW-1:0]                               addr,
  input  logic [CW-1:0]                                 wdata,
  output logic [ofe_pkg::NBANK-1:0][NSAMP-1:0][CW-1:0]  tab
);
  logic addr_ok;
  assign addr_ok = (int'(addr) < NSAMP);

  for (genvar b = 0; b < ofe_pkg::NBANK; b++) begin : g_bank
    logic [CW-1:0] mem [NSAMP];
    logic          hit;
    assign hit = we && addr_ok && (sel == 2'(b));

    always_ff @(posedge clk) begin
      if (hit) mem[addr] <= wdata;
    end

    for (genvar i = 0; i < NSAMP; i++) begin : g_rd
      assign tab[b][i] = mem[i];
    end
  end
endmodule

// File: rtl/ofe_mac.sv
module ofe_mac #(
  parameter int SW = 10,
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 first,
  input  logic [SW-1:0]        sample,
  input  logic [CW-1:0]        weight,
  output logic signed [AW-1:0] sum_next
);
  logic signed [CW-1:0]   xs;
  logic signed [CW-1:0]   ws;
  logic signed [2*CW-1:0] prod;
  logic signed [AW-1:0]   acc;

  assign xs       = $signed(CW'(sample));
  assign ws       = $signed(weight);
  assign prod     = xs * ws;
  assign sum_next = (first ? '0 : acc) + AW'(prod);

  always_ff @(posedge clk) begin
    if (en) acc <= sum_next;
  end
endmodule

// File: rtl/ofe_chi.sv
module ofe_chi #(
  parameter int NSAMP = 7,
  parameter int SW    = 10,
  parameter int CW    = 16,
  parameter int AW    = 32,
  parameter int FRAC  = 14,
  parameter int IDXW  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_bank,
  input  logic [IDXW-1:0]              wr_idx,
  input  logic [SW-1:0]                wr_data,
  input  logic                         start,
  input  logic                         start_bank,
  input  logic signed [AW-1:0]         start_e,
  input  logic signed [AW-1:0]         start_et,
  input  logic [NSAMP-1:0][CW-1:0]     g_tab,
  output logic                         done,
  output logic [AW-1:0]                done_e,
  output logic [AW-1:0]                done_et,
  output logic [AW-1:0]                done_chi
);
  localparam logic signed [AW-1:0] CMAX = AW'((1 << (CW-1)) - 1);
  localparam logic signed [AW-1:0] CMIN = -CMAX - 1;

  function automatic logic signed [CW-1:0] clamp_cw(input logic signed [AW-1:0] v);
    if (v > CMAX)      return CMAX[CW-1:0];
    else if (v < CMIN) return CMIN[CW-1:0];
    else               return v[CW-1:0];
  endfunction

  logic [SW-1:0]          sbuf [2][NSAMP];
  logic                   busy;
  logic                   bsel;
  logic [IDXW-1:0]        idx;
  logic signed [AW-1:0]   e_hold;
  logic signed [AW-1:0]   et_hold;
  logic [AW-1:0]          chiacc;

  logic signed [CW-1:0]   e16;
  logic signed [CW-1:0]   gv;
  logic signed [2*CW-1:0] fitp;
  logic signed [AW-1:0]   fit;
  logic [SW-1:0]          s_cur;
  logic signed [AW-1:0]   resid;
  logic signed [CW-1:0]   r16;
  logic signed [2*CW-1:0] sq;
  logic [AW:0]            chi_sum;
  logic [AW-1:0]          chi_next;

  always_ff @(posedge clk) begin
    if (wr_en) sbuf[wr_bank][wr_idx] <= wr_data;
  end

  assign e16      = clamp_cw(e_hold);
  assign gv       = $signed(g_tab[idx]);
  assign fitp     = e16 * gv;
  assign fit      = AW'(fitp) >>> FRAC;
  assign s_cur    = sbuf[bsel][idx];
  assign resid    = AW'($signed({1'b0, s_cur})) - fit;
  assign r16      = clamp_cw(resid);
  assign sq       = r16 * r16;
  assign chi_sum  = {1'b0, chiacc} + (AW+1)'($unsigned(sq));
  assign chi_next = chi_sum[AW] ? '1 : chi_sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      bsel     <= 1'b0;
      idx      <= '0;
      e_hold   <= '0;
      et_hold  <= '0;
      chiacc   <= '0;
      done     <= 1'b0;
      done_e   <= '0;
      done_et  <= '0;
      done_chi <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (int'(idx) == NSAMP-1) begin
          done     <= 1'b1;
          done_e   <= e_hold;
          done_et  <= et_hold;
          done_chi <= chi_next;
          busy     <= 1'b0;
        end else begin
          chiacc <= chi_next;
          idx    <= idx + 1'b1;
        end
      end
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        chiacc  <= '0;
        bsel    <= start_bank;
        e_hold  <= start_e;
        et_hold <= start_et;
      end
    end
  end
endmodule

// File: rtl/ofe_delay.sv
module ofe_delay #(
  parameter int DEPTH = 9,
  parameter int W     = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  if (DEPTH == 0) begin : g_pass
    assign out_v = in_v;
    assign out_d = in_d;
  end else begin : g_pipe
    logic [DEPTH-1:0] vld;
    logic [W-1:0]     dat [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        vld <= '0;
        for (int k = 0; k < DEPTH; k++) dat[k] <= '0;
      end else begin
        vld[0] <= in_v;
        if (in_v) dat[0] <= in_d;
        for (int k = 1; k < DEPTH; k++) begin
          vld[k] <= vld[k-1];
          if (vld[k-1]) dat[k] <= dat[k-1];
        end
      end
    end

    assign out_v = vld[DEPTH-1];
    assign out_d = dat[DEPTH-1];
  end
endmodule

// File: rtl/ofe_engine.sv
module ofe_engine #(
  parameter  int NSAMP = 7,
  parameter  int SW    = 10,
  parameter  int CW    = 16,
  parameter  int AW    = 32,
  parameter  int FRAC  = 14,
  parameter  int LAT   = 16,
  localparam int IDXW  = $clog2(NSAMP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [IDXW-1:0] cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  input  logic            smp_valid,
  input  logic [SW-1:0]   smp_data,
  output logic            res_valid,
  output logic [AW-1:0]   res_energy,
  output logic [AW-1:0]   res_etime,
  output logic [AW-1:0]   res_chi2
);
  localparam int DLY  = LAT - NSAMP;
  localparam int RECW = 3 * AW;

  logic [ofe_pkg::NBANK-1:0][NSAMP-1:0][CW-1:0] tab;
  logic [IDXW-1:0]      cnt;
  logic                 wbank;
  logic                 smp_last;
  logic                 start;
  logic signed [AW-1:0] wsum [2];
  logic signed [AW-1:0] e_scaled;
  logic signed [AW-1:0] et_scaled;
  logic                 done;
  logic [AW-1:0]        done_e;
  logic [AW-1:0]        done_et;
  logic [AW-1:0]        done_chi;
  logic [RECW-1:0]      rec_out;

  assign smp_last = (int'(cnt) == NSAMP-1);
  assign start    = smp_valid && smp_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      wbank <= 1'b0;
    end else if (smp_valid) begin
      if (smp_last) begin
        cnt   <= '0;
        wbank <= ~wbank;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  ofe_coef_bank #(.NSAMP(NSAMP), .CW(CW), .IDXW(IDXW)) u_coef (
    .clk   (clk),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .tab   (tab)
  );

  for (genvar w = 0; w < 2; w++) begin : g_mac
    ofe_mac #(.SW(SW), .CW(CW), .AW(AW)) u_mac (
      .clk      (clk),
      .en       (smp_valid),
      .first    (cnt == '0),
      .sample   (smp_data),
      .weight   (tab[w][cnt]),
      .sum_next (wsum[w])
    );
  end

  assign e_scaled  = wsum[0] >>> FRAC;
  assign et_scaled = wsum[1] >>> FRAC;

  ofe_chi #(.NSAMP(NSAMP), .SW(SW), .CW(CW), .AW(AW), .FRAC(FRAC), .IDXW(IDXW)) u_chi (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (smp_valid),
    .wr_bank    (wbank),
    .wr_idx     (cnt),
    .wr_data    (smp_data),
    .start      (start),
    .start_bank (wbank),
    .start_e    (e_scaled),
    .start_et   (et_scaled),
    .g_tab      (tab[2]),
    .done       (done),
    .done_e     (done_e),
    .done_et    (done_et),
    .done_chi   (done_chi)
  );

  ofe_delay #(.DEPTH(DLY), .W(RECW)) u_dly (
    .clk   (clk),
    .rst   (rst),
    .in_v  (done),
    .in_d  ({done_e, done_et, done_chi}),
    .out_v (res_valid),
    .out_d (rec_out)
  );

  assign res_energy = rec_out[3*AW-1:2*AW];
  assign res_etime  = rec_out[2*AW-1:AW];
  assign res_chi2   = rec_out[AW-1:0];
endmodule

// File: rtl/ofe_engine_chk.sv
module ofe_engine_chk #(
  parameter int NSAMP = 7,
  parameter int LAT   = 16,
  parameter int AW    = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic          res_valid,
  input logic [AW-1:0] res_energy,
  input logic [AW-1:0] res_etime,
  input logic [AW-1:0] res_chi2
);
  localparam int CNTW = $clog2(NSAMP);

  logic [CNTW-1:0] seen;
  logic [LAT:0]    hist;
  logic            closing;

  assign closing = smp_valid && (int'(seen) == NSAMP-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      hist <= '0;
    end else begin
      if (smp_valid) seen <= closing ? '0 : seen + 1'b1;
      hist <= {hist[LAT-1:0], closing};
    end
  end

  // R6: pulse follows each closing sample by LAT edges
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid == hist[LAT]);

  // R10: channels take at least NSAMP cycles each, so pulses never touch
  a_r10_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R11: outputs hold while no pulse is present
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_energy) && $stable(res_etime) && $stable(res_chi2)));

  // R1: cleared outputs on the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && res_energy == '0 && res_etime == '0 && res_chi2 == '0));
endmodule

bind ofe_engine ofe_engine_chk #(.NSAMP(NSAMP), .LAT(LAT), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .res_valid  (res_valid),
  .res_energy (res_energy),
  .res_etime  (res_etime),
  .res_chi2   (res_chi2)
);

// File: tb/tb_ofe_engine.sv
module tb_ofe_engine;
  localparam int NS  = 7;
  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        smp_valid = 1'b0;
  logic [9:0]  smp_data = 10'd0;
  logic        res_valid;
  logic [31:0] res_energy, res_etime, res_chi2;

  always #10 clk = ~clk;

  ofe_engine dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
    .res_valid(res_valid), .res_energy(res_energy), .res_etime(res_etime), .res_chi2(res_chi2)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ca [NS], cb [NS], cg [NS];
  int smp [NS];

  longint     exp_e [1024], exp_et [1024], exp_chi [1024], exp_cyc [1024];
  string      exp_tag [1024];
  logic [31:0] act_e [1024], act_et [1024], act_chi [1024];
  int wr_p = 0, rd_p = 0;
  int rng = 32'h1234abcd;

  function automatic int nextr();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model(output longint e, output longint et, output longint chi);
    longint sa = 0, sb = 0, c = 0;
    for (int i = 0; i < NS; i++) begin
      sa += longint'(smp[i]) * ca[i];
      sb += longint'(smp[i]) * cb[i];
    end
    e  = sa >>> 14;
    et = sb >>> 14;
    for (int i = 0; i < NS; i++) begin
      longint fit = (clamp16(e) * cg[i]) >>> 14;
      longint r   = clamp16(longint'(smp[i]) - fit);
      c += r * r;
    end
    chi = (c > 64'hFFFFFFFF) ? 64'hFFFFFFFF : c;
  endtask

  task automatic cfg_write(input int sel, input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 3'(addr); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_tables();
    for (int i = 0; i < NS; i++) begin
      cfg_write(0, i, ca[i]);
      cfg_write(1, i, cb[i]);
      cfg_write(2, i, cg[i]);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  // send the channel held in smp; gap_max>0 inserts random idle cycles
  task automatic send_chan(input int gap_max, input string tag);
    longint e, et, chi;
    model(e, et, chi);
    for (int i = 0; i < NS; i++) begin
      if (gap_max > 0) begin
        int g = (nextr() & 32'h7fffffff) % (gap_max + 1);
        for (int k = 0; k < g; k++) begin
          @(negedge clk); smp_valid = 1'b0;
        end
      end
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 10'(smp[i]);
    end
    @(posedge clk);
    #1;
    exp_e[wr_p] = e; exp_et[wr_p] = et; exp_chi[wr_p] = chi;
    exp_cyc[wr_p] = cyc + LAT; exp_tag[wr_p] = tag;
    wr_p++;
  endtask

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (rd_p == wr_p) begin
        check(1'b0, "R6", "unexpected result pulse", 1, 0);
      end else begin
        string t = exp_tag[rd_p];
        string chireq = (exp_chi[rd_p] == 64'hFFFFFFFF) ? "R7" : "R4";
        check(res_energy == 32'(exp_e[rd_p]), "R2", {"energy ", t},
              longint'($signed(res_energy)), exp_e[rd_p]);
        check(res_etime == 32'(exp_et[rd_p]), "R3", {"etime ", t},
              longint'($signed(res_etime)), exp_et[rd_p]);
        check(res_chi2 == 32'(exp_chi[rd_p]), chireq, {"chi2 ", t},
              longint'(res_chi2), exp_chi[rd_p]);
        check(cyc == exp_cyc[rd_p], "R6", {"latency cycle ", t}, cyc, exp_cyc[rd_p]);
        act_e[rd_p] = res_energy; act_et[rd_p] = res_etime; act_chi[rd_p] = res_chi2;
        rd_p++;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p5a, p5b;
    for (int i = 0; i < NS; i++) begin
      ca[i] = i * 5000 - 12000;
      cb[i] = 9000 - i * 2900;
      cg[i] = 16384 - (i - 3) * (i - 3) * 1800;
    end
    repeat (3) @(negedge clk);
    #1;
    check(res_valid == 1'b0, "R1", "valid during reset", res_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);
    check(res_energy == 0 && res_etime == 0 && res_chi2 == 0, "R1", "data after reset",
          longint'(res_energy | res_etime | res_chi2), 0);

    load_tables();

    // fixed patterns
    for (int i = 0; i < NS; i++) smp[i] = 0;
    send_chan(0, "R2 zero");
    for (int i = 0; i < NS; i++) smp[i] = 1023;
    send_chan(0, "full scale");
    for (int i = 0; i < NS; i++) smp[i] = i * 150 + 10;
    send_chan(0, "ramp");
    idle(25);

    // R5: repeated sample set around other channels
    for (int i = 0; i < NS; i++) smp[i] = (i * 377 + 91) % 1024;
    p5a = wr_p;
    send_chan(0, "R5 first");
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < NS; i++) smp[i] = (nextr() & 32'h7fffffff) % 1024;
      send_chan(0, "R10 back-to-back");
    end
    for (int i = 0; i < NS; i++) smp[i] = (i * 377 + 91) % 1024;
    p5b = wr_p;
    send_chan(0, "R5 second");

    // R9: gapped channels
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < NS; i++) smp[i] = (nextr() & 32'h7fffffff) % 1024;
      send_chan(3, "R9 gapped");
    end
    idle(30);

    // R11: outputs hold the last record
    check(res_energy == act_e[rd_p-1] && res_chi2 == act_chi[rd_p-1], "R11", "hold after drain",
          longint'(res_energy), longint'(act_e[rd_p-1]));

    // R8: writes to the unused bank select and to an out-of-range index
    for (int i = 0; i < NS; i++) cfg_write(3, i, 16'h7fff);
    cfg_write(0, 7, 16'h7fff);
    cfg_write(1, 7, 16'h8000);
    cfg_write(2, 7, 16'h7fff);
    for (int i = 0; i < NS; i++) smp[i] = 512 + i * 40;
    send_chan(0, "R8 ignored writes");
    idle(25);

    // R7: force chi-square saturation
    for (int i = 0; i < NS; i++) begin
      ca[i] = 32767; cb[i] = 1000; cg[i] = -32768;
    end
    load_tables();
    for (int i = 0; i < NS; i++) smp[i] = 1023;
    send_chan(0, "R7 saturate");
    idle(25);

    check(rd_p == wr_p, "R6", "one record per channel", rd_p, wr_p);
    check(act_e[p5a] == act_e[p5b], "R5", "repeat energy", longint'(act_e[p5b]), longint'(act_e[p5a]));
    check(act_et[p5a] == act_et[p5b], "R5", "repeat etime", longint'(act_et[p5b]), longint'(act_et[p5a]));
    check(act_chi[p5a] == act_chi[p5b], "R5", "repeat chi2", longint'(act_chi[p5b]), longint'(act_chi[p5a]));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule